// File: doc/BRIEF.md
# Back-Porch Clamp Pulse Generator

This block creates the internal clamp pulse that gates a video input clamp during the back porch, plus a second pulse that gates the output-level sample-and-hold. A trigger starts the clamp pulse. The trigger can be either edge of the horizontal sync, or the start of the blanking interval. The block finds the sync polarity by itself. Blanking polarity comes from a control pin. The pulse lasts one of four programmed widths, roughly one third of a microsecond apart. The widths are turned into clock cycles from a clock-frequency parameter.

An 8-bit control byte sets the behaviour. It picks the trigger source, the sync edge and the width. It can also pass an external clamp pulse, fed on the sync pin, straight through. It selects whether the output pulse follows blanking or the internal clamp pulse. Two test bits hold either output high. All inputs are synchronous to the pixel clock.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While reset is asserted, `clamp_o` and `ocl_o` are 0 (with `ctrl_i` = 0x02, `blank_i` = 0 and `blank_neg_i` = 0). The sync polarity starts as active-high.
- R2: With `ctrl_i[0]`=0 and `ctrl_i[1]`=1, the pulse is triggered by the leading edge of sync. `clamp_o` goes high one clock after the edge that first samples the new sync level.
- R3: With `ctrl_i[0]`=0 and `ctrl_i[1]`=0, the pulse is triggered by the trailing edge of sync. The leading edge causes no pulse.
- R4: Sync polarity is decided on every rising edge of `hsync_i`. The cycles spent high and low since the previous rising edge are compared, and the shorter level is taken as active. Leading and trailing then refer to that active level.
- R5: `ctrl_i[3:2]` selects the width, rounded to the nearest clock: 0 → 1/3 µs, 1 → 2/3 µs, 2 → 1 µs, 3 → 4/3 µs. At 125 MHz this gives 42, 83, 125 and 167 cycles.
- R6: A trigger that arrives while a pulse is active is ignored. The running pulse keeps its length.
- R7: With `ctrl_i[0]`=1, the pulse is triggered by the leading edge of `blank_i`. That edge is rising when `blank_neg_i`=0 and falling when `blank_neg_i`=1. Sync edges and the blanking trailing edge cause no pulse.
- R8: With `ctrl_i[4]`=1, `clamp_o` equals `hsync_i` delayed by one clock, and no pulse is generated.
- R9: `ctrl_i[5]`=1 forces `clamp_o` to 1, and `ctrl_i[6]`=1 forces `ocl_o` to 1. Each bit leaves the other output alone, and both act in the cycle they are set.
- R10: With `ctrl_i[7]`=0, `ocl_o` is the active blanking level (`blank_i` XOR `blank_neg_i`) delayed by one clock. With `ctrl_i[7]`=1, it equals the internal clamp pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync of either polarity, or an external clamp pulse in bypass |
| blank_i | input | 1 | Blanking pulse |
| blank_neg_i | input | 1 | 1 = blanking is active-low |
| ctrl_i | input | 8 | Control byte: b0 source, b1 edge, b3:2 width, b4 bypass, b5/b6 forces, b7 output-pulse source |
| clamp_o | output | 1 | Internal back-porch clamp pulse |
| ocl_o | output | 1 | Output-level clamp pulse |

## Verification
The input edge is registered once. A generated pulse therefore rises in the clock after the rising edge that first samples the triggering level, and stays high for exactly the selected count of cycles. The bypass and the blanking-derived output follow their inputs with the same one-clock delay. The force bits act in the same cycle as the control change. The bench's driver stamps every expected value with the absolute rising-edge count at which it is due, taken from the negative edge on which the stimulus is applied. The monitor samples 2 ns after each rising edge and compares only the queue items stamped with that count. This places checks on the first and last high cycles and on the first low cycle of each pulse.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

   localparam int NUM_WIDTHS = 4;

   // control byte layout, most significant field first
   typedef struct packed {
      logic       ocl_from_pulse;
      logic       force_ocl;
      logic       force_clamp;
      logic       bypass;
      logic [1:0] width;
      logic       lead_edge;
      logic       src_blank;
   } ctrl_t;

   // pulse length in clocks for width code idx: (idx+1)/3 us, nearest cycle
   function automatic int width_cycles(longint clk_hz, int idx);
      longint num;
      num = clk_hz * longint'(idx + 1) * 2 + 64'sd3_000_000;
      return int'(num / 64'sd6_000_000);
   endfunction

endpackage

// File: rtl/cpg_hs_polarity.sv
module cpg_hs_polarity #(
   parameter int LINE_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_raw,
   input  logic hs_rise,
   output logic pol_low
);

   logic [LINE_W-1:0] hi_cnt;
   logic [LINE_W-1:0] lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt  <= '0;
         lo_cnt  <= '0;
         pol_low <= 1'b0;
      end else if (hs_rise) begin
         if (hi_cnt > lo_cnt) begin
            pol_low <= 1'b1;
         end else if (hi_cnt < lo_cnt) begin
            pol_low <= 1'b0;
         end
         hi_cnt <= LINE_W'(1);
         lo_cnt <= '0;
      end else if (hs_raw) begin
         if (hi_cnt != '1) begin
            hi_cnt <= hi_cnt + 1'b1;
         end
      end else begin
         if (lo_cnt != '1) begin
            lo_cnt <= lo_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cpg_edge_sel.sv
module cpg_edge_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_raw,
   input  logic blank_raw,
   input  logic blank_neg,
   input  logic pol_low,
   input  logic src_blank,
   input  logic lead_edge,
   output logic hs_q,
   output logic blank_q,
   output logic hs_rise,
   output logic trig
);

   logic hs_fall;
   logic hs_lead;
   logic hs_trail;
   logic bl_lead;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q    <= 1'b0;
         blank_q <= 1'b0;
      end else begin
         hs_q    <= hs_raw;
         blank_q <= blank_raw;
      end
   end

   assign hs_rise  = hs_raw & ~hs_q;
   assign hs_fall  = ~hs_raw & hs_q;
   assign hs_lead  = pol_low ? hs_fall : hs_rise;
   assign hs_trail = pol_low ? hs_rise : hs_fall;
   assign bl_lead  = blank_neg ? (~blank_raw & blank_q) : (blank_raw & ~blank_q);
   assign trig     = src_blank ? bl_lead : (lead_edge ? hs_lead : hs_trail);

endmodule

// File: rtl/cpg_pulse_timer.sv
module cpg_pulse_timer
   import cpg_pkg::*;
#(
   parameter int CLK_HZ = 125_000_000,
   parameter int CNT_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic [1:0]       width,
   output logic             active,
   output logic [CNT_W-1:0] left
);

   logic [CNT_W-1:0] wtab [NUM_WIDTHS];

   for (genvar i = 0; i < NUM_WIDTHS; i++) begin : g_wtab
      localparam int CYC = width_cycles(CLK_HZ, i);
      assign wtab[i] = CNT_W'(CYC - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         left   <= '0;
      end else if (!active) begin
         if (trig) begin
            active <= 1'b1;
            left   <= wtab[width];
         end
      end else if (left == '0) begin
         active <= 1'b0;
      end else begin
         left <= left - 1'b1;
      end
   end

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
   import cpg_pkg::*;
#(
   parameter int CLK_HZ = 125_000_000,
   parameter int LINE_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hsync_i,
   input  logic       blank_i,
   input  logic       blank_neg_i,
   input  logic [7:0] ctrl_i,
   output logic       clamp_o,
   output logic       ocl_o
);

   localparam int MAX_CYC = width_cycles(CLK_HZ, NUM_WIDTHS - 1);
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (CLK_HZ < 3_000_000) begin : g_bad_clk
      $error("clamp_pulse_gen: CLK_HZ too low for the shortest width");
   end
   if (LINE_W < 4) begin : g_bad_line
      $error("clamp_pulse_gen: LINE_W must be at least 4");
   end

   ctrl_t            ctl;
   logic             hs_q;
   logic             blank_q;
   logic             hs_rise;
   logic             trig;
   logic             pol_low;
   logic             tmr_active;
   logic [CNT_W-1:0] tmr_left;
   logic             bpcp_int;

   assign ctl = ctrl_t'(ctrl_i);

   cpg_hs_polarity #(.LINE_W(LINE_W)) u_pol (
      .clk     (clk),
      .rst_n   (rst_n),
      .hs_raw  (hsync_i),
      .hs_rise (hs_rise),
      .pol_low (pol_low)
   );

   cpg_edge_sel u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .hs_raw    (hsync_i),
      .blank_raw (blank_i),
      .blank_neg (blank_neg_i),
      .pol_low   (pol_low),
      .src_blank (ctl.src_blank),
      .lead_edge (ctl.lead_edge),
      .hs_q      (hs_q),
      .blank_q   (blank_q),
      .hs_rise   (hs_rise),
      .trig      (trig)
   );

   cpg_pulse_timer #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (trig),
      .width  (ctl.width),
      .active (tmr_active),
      .left   (tmr_left)
   );

   assign bpcp_int = ctl.force_clamp | (ctl.bypass ? hs_q : tmr_active);
   assign clamp_o  = bpcp_int;
   assign ocl_o    = ctl.force_ocl |
                     (ctl.ocl_from_pulse ? bpcp_int : (blank_q ^ blank_neg_i));

endmodule

// File: rtl/cpg_chk.sv
module cpg_chk
   import cpg_pkg::*;
#(
   parameter int CLK_HZ = 125_000_000,
   parameter int CNT_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hsync_i,
   input logic             clamp_o,
   input logic             bypass_en,
   input logic             force_clamp,
   input logic [1:0]       width_sel,
   input logic             trig,
   input logic             hs_rise,
   input logic             pol_low,
   input logic             tmr_active,
   input logic [CNT_W-1:0] tmr_left
);

   logic       past_ok;
   logic [1:0] run_sel;
   int         run_len;
   int         exp_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         past_ok <= 1'b0;
         run_sel <= '0;
         run_len <= 0;
      end else begin
         past_ok <= 1'b1;
         if (trig && !tmr_active) begin
            run_sel <= width_sel;
            run_len <= 1;
         end else if (tmr_active && tmr_left != '0) begin
            run_len <= run_len + 1;
         end
      end
   end

   always_comb exp_len = width_cycles(CLK_HZ, int'(run_sel));

   // R5
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tmr_active) |-> run_len == exp_len);

   // R2
   start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_active) |-> $past(trig));

   // R6
   no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_active && tmr_left != '0) |=> (tmr_active && tmr_left + 1'b1 == $past(tmr_left)));

   // R8
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && bypass_en && !force_clamp) |-> clamp_o == $past(hsync_i));

   // R4
   pol_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && pol_low != $past(pol_low)) |-> $past(hs_rise));

endmodule

bind clamp_pulse_gen cpg_chk #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hsync_i     (hsync_i),
   .clamp_o     (clamp_o),
   .bypass_en   (ctrl_i[4]),
   .force_clamp (ctrl_i[5]),
   .width_sel   (ctrl_i[3:2]),
   .trig        (trig),
   .hs_rise     (hs_rise),
   .pol_low     (pol_low),
   .tmr_active  (tmr_active),
   .tmr_left    (tmr_left)
);

// File: tb/tb_clamp_pulse_gen.sv
module tb_clamp_pulse_gen;

   typedef struct {
      int    cyc;
      bit    sig;
      bit    val;
      string tag;
   } exp_t;

   logic       clk;
   logic       rst_n;
   logic       hsync_i;
   logic       blank_i;
   logic       blank_neg_i;
   logic [7:0] ctrl_i;
   logic       clamp_o;
   logic       ocl_o;

   exp_t q[$];
   int   cyc    = 0;
   int   checks = 0;
   int   errors = 0;
   int   nw[4]  = '{42, 83, 125, 167};

   clamp_pulse_gen dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .hsync_i     (hsync_i),
      .blank_i     (blank_i),
      .blank_neg_i (blank_neg_i),
      .ctrl_i      (ctrl_i),
      .clamp_o     (clamp_o),
      .ocl_o       (ocl_o)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   task automatic push(int off, bit sig, bit val, string tag);
      exp_t it;
      it.cyc = cyc + off;
      it.sig = sig;
      it.val = val;
      it.tag = tag;
      q.push_back(it);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hs_line(bit neg_pol, int sync_len, int line_len);
      hsync_i = ~neg_pol;
      idle(sync_len);
      hsync_i = neg_pol;
      idle(line_len - sync_len);
   endtask

   // monitor: compares items due at this rising-edge count
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         #2;
         while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t it;
            bit   act;
            it  = q.pop_front();
            act = it.sig ? ocl_o : clamp_o;
            checks++;
            if (it.cyc != cyc || act !== it.val) begin
               errors++;
               $display("FAIL %s cyc %0d %s actual %0b expected %0b",
                        it.tag, it.cyc, it.sig ? "ocl_o" : "clamp_o", act, it.val);
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n       = 1'b0;
      hsync_i     = 1'b0;
      blank_i     = 1'b0;
      blank_neg_i = 1'b0;
      ctrl_i      = 8'h02;
      idle(3);
      // R1 reset state
      checks++;
      if (clamp_o !== 1'b0 || ocl_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset actual %0b%0b expected 00", clamp_o, ocl_o);
      end
      rst_n = 1'b1;
      idle(5);

      // settle polarity on positive sync
      hs_line(0, 48, 400);
      hs_line(0, 48, 400);

      // R2 leading edge, R5 all four widths
      for (int w = 0; w < 4; w++) begin
         ctrl_i = {4'b0000, 2'(w), 2'b10};
         push(1, 0, 1, "R2");
         push(nw[w], 0, 1, "R5");
         push(nw[w] + 1, 0, 0, "R5");
         hs_line(0, 48, 400);
      end

      // R3 trailing edge
      ctrl_i = 8'h00;
      push(1, 0, 0, "R3");
      push(49, 0, 1, "R3");
      push(90, 0, 1, "R3");
      push(91, 0, 0, "R3");
      hs_line(0, 48, 400);

      // R4 negative sync: settle, then leading and trailing
      ctrl_i = 8'h02;
      hs_line(1, 48, 400);
      hs_line(1, 48, 400);
      push(1, 0, 1, "R4");
      push(42, 0, 1, "R4");
      push(43, 0, 0, "R4");
      push(49, 0, 0, "R4");
      hs_line(1, 48, 400);
      ctrl_i = 8'h00;
      push(1, 0, 0, "R4");
      push(49, 0, 1, "R4");
      push(91, 0, 0, "R4");
      hs_line(1, 48, 400);

      // back to positive sync
      ctrl_i = 8'h02;
      hs_line(0, 48, 400);
      hs_line(0, 48, 400);
      hs_line(0, 48, 400);

      // R6 retrigger during a 167-cycle pulse is ignored
      ctrl_i = 8'h0E;
      push(1, 0, 1, "R6");
      push(101, 0, 1, "R6");
      push(167, 0, 1, "R6");
      push(168, 0, 0, "R6");
      hs_line(0, 20, 100);
      hs_line(0, 20, 100);
      hs_line(0, 48, 400);

      // R7 blanking source, sync ignored
      ctrl_i = 8'h01;
      idle(10);
      push(1, 0, 0, "R7");
      push(5, 0, 0, "R7");
      hsync_i = 1'b1;
      idle(10);
      hsync_i = 1'b0;
      idle(10);
      // positive blanking, R10 output from blanking
      push(1, 0, 1, "R7");
      push(1, 1, 1, "R10");
      push(42, 0, 1, "R7");
      push(43, 0, 0, "R7");
      push(60, 1, 1, "R10");
      push(61, 1, 0, "R10");
      blank_i = 1'b1;
      idle(60);
      blank_i = 1'b0;
      idle(100);
      // negative blanking
      blank_neg_i = 1'b1;
      blank_i     = 1'b1;
      idle(20);
      push(1, 0, 1, "R7");
      push(1, 1, 1, "R10");
      push(42, 0, 1, "R7");
      push(43, 0, 0, "R7");
      push(60, 1, 1, "R10");
      push(61, 1, 0, "R10");
      push(62, 0, 0, "R7");
      blank_i = 1'b0;
      idle(60);
      blank_i = 1'b1;
      idle(100);

      // R10 output pulse follows the internal clamp pulse
      ctrl_i = 8'h8D;
      push(1, 1, 1, "R10");
      push(100, 1, 1, "R10");
      push(167, 1, 1, "R10");
      push(168, 1, 0, "R10");
      blank_i = 1'b0;
      idle(60);
      blank_i = 1'b1;
      idle(200);

      // R8 bypass
      ctrl_i = 8'h10;
      idle(2);
      push(1, 0, 1, "R8");
      push(10, 0, 1, "R8");
      push(11, 0, 0, "R8");
      hsync_i = 1'b1;
      idle(10);
      hsync_i = 1'b0;
      idle(100);

      // R9 force bits
      ctrl_i = 8'h20;
      push(1, 0, 1, "R9");
      push(1, 1, 0, "R9");
      idle(5);
      ctrl_i = 8'h40;
      push(1, 0, 0, "R9");
      push(1, 1, 1, "R9");
      idle(5);
      ctrl_i = 8'h00;
      idle(10);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule